// File: doc/BRIEF.md
# Banked Level Interrupt Controller with Shortcut Word

This block gathers 72 level-sensitive interrupt lines and drives one interrupt request to a processor. Eight lines are local to the processor and 64 come from peripherals, split into two banks of 32. Each line has an enable bit. A line counts as pending while its level is high and it is enabled. Only pending lines can raise the request.

Software reaches the controller through a plain 32-bit register port. Each group of lines has two write strobes. One sets enable bits and the other clears them, so setting or clearing a line never needs a read-modify-write. The first status word reports the local lines directly, a summary bit for each bank, and copies of eleven frequently used bank lines. For those eleven lines, one read is enough to find the source. Each bank also has its own full status word. Source numbering is global: local lines are 0 to 7, bank one is 8 to 39 and bank two is 40 to 71. A source's bit inside its bank is its global number minus the bank base.

The port carries single-word register accesses and has no flow control. A write takes effect at the clock edge on which `reg_wr` is high. Read data is a combinational function of `reg_addr` and the current state, and there is no read strobe. The interrupt lines are plain level inputs and the request is a plain level output, so there is no valid/ready handshake anywhere and no back-pressure.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset every enable bit is 0, `irq_out` is 0, and every mapped register reads 0.
- R2: A write to a set-enable address sets the enable bit for each 1 in the data and leaves the other bits unchanged. The addresses are 0x18 for local lines on bits 7:0, 0x10 for bank one and 0x14 for bank two.
- R3: A write to a clear-enable address clears the enable bit for each 1 in the data and leaves the other bits unchanged. The addresses are 0x24 for local lines, 0x1C for bank one and 0x20 for bank two.
- R4: Reading a clear-enable address returns the same enable mask as reading the matching set-enable address. The local mask is zero-extended.
- R5: Address 0x04 reads bank one's pending word and 0x08 reads bank two's. Bit i of a pending word is level AND enable of that bank's line i.
- R6: Bits 7:0 of the first status word at address 0x00 are level AND enable of the local lines.
- R7: Bit 8 of the first status word is 1 when any bank-one line is pending, and bit 9 is 1 when any bank-two line is pending. This includes lines that also have a copy bit.
- R8: Bits 10 to 14 of the first status word copy the pending state of bank-one lines 7, 9, 10, 18 and 19, in that order. Bits 15 to 20 copy the pending state of bank-two lines 21, 22, 23, 24, 25 and 30, in that order.
- R9: Bits 31:21 of the first status word always read 0.
- R10: Writes to the status addresses (0x00, 0x04, 0x08) and to the reserved address 0x0C change no state. Address 0x0C always reads 0.
- R11: `irq_out` is the OR of all pending lines, delayed by one clock. It stays high while any pending line remains, and it falls one clock after the last pending line goes away.
- R12: Read data follows `reg_addr` in the same cycle, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe; the write happens on this clock edge |
| reg_addr | input | 6 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| local_lvl | input | 8 | Local interrupt levels (sources 0 to 7) |
| bank1_lvl | input | 32 | Bank-one interrupt levels (sources 8 to 39) |
| bank2_lvl | input | 32 | Bank-two interrupt levels (sources 40 to 71) |
| irq_out | output | 1 | Registered interrupt request to the processor |

## Verification
The bench drives inputs at the falling clock edge and samples 1 ns later, well clear of the rising edge.

- **Enable writes.** A write's effect on the enable masks, and on every status word derived from them, is due at the first falling edge after the rising edge that took the write. The bench reads back there.
- **Level changes.** A change on the level inputs is visible in the read data within the same cycle, with no clock in between.
- **Interrupt request.** `irq_out` has one register in its path. Each test that checks it samples once right after the causing event, where the old value is expected. It samples again after one more rising edge, where the new value is expected.

// File: rtl/banked_irq_pkg.sv
package banked_irq_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 6;
  localparam int LOCAL_N = 8;
  localparam int BANK_W  = 32;

  // register byte offsets
  localparam logic [ADDR_W-1:0] OFS_STATUS  = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_B1_PEND = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_B2_PEND = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_RSVD    = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_B1_SET  = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_B2_SET  = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_LOC_SET = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_B1_CLR  = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_B2_CLR  = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_LOC_CLR = 6'h24;

  // shortcut copies: element 0 lands on the lowest copy bit
  localparam int B1_SC_N = 5;
  localparam int B2_SC_N = 6;
  localparam logic [B1_SC_N-1:0][4:0] B1_SC = {5'd19, 5'd18, 5'd10, 5'd9, 5'd7};
  localparam logic [B2_SC_N-1:0][4:0] B2_SC = {5'd30, 5'd25, 5'd24, 5'd23, 5'd22, 5'd21};

  // derived positions inside the first status word
  localparam int SUM1_BIT = LOCAL_N;
  localparam int SUM2_BIT = LOCAL_N + 1;
  localparam int SC1_BASE = LOCAL_N + 2;
  localparam int SC2_BASE = SC1_BASE + B1_SC_N;
  localparam int USED_W   = SC2_BASE + B2_SC_N;
endpackage

// File: rtl/irq_mask_group.sv
module irq_mask_group #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en <= '0;
    else if (set_we) en <= en | wdata;
    else if (clr_we) en <= en & ~wdata;
  end

  // R2
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((en & $past(wdata)) == $past(wdata)));
  // R3
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we) |=> ((en & $past(wdata)) == '0));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(en));
endmodule

// File: rtl/irq_status_view.sv
module irq_status_view
  import banked_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LOCAL_N-1:0] loc_lvl,
  input  logic [LOCAL_N-1:0] loc_en,
  input  logic [BANK_W-1:0] b1_lvl,
  input  logic [BANK_W-1:0] b1_en,
  input  logic [BANK_W-1:0] b2_lvl,
  input  logic [BANK_W-1:0] b2_en,
  output logic [BANK_W-1:0] b1_pend,
  output logic [BANK_W-1:0] b2_pend,
  output logic [DATA_W-1:0] status_word,
  output logic              any_pend
);
  logic [LOCAL_N-1:0] loc_pend;
  logic [B1_SC_N-1:0] sc1;
  logic [B2_SC_N-1:0] sc2;

  assign loc_pend = loc_lvl & loc_en;
  assign b1_pend  = b1_lvl & b1_en;
  assign b2_pend  = b2_lvl & b2_en;

  for (genvar i = 0; i < B1_SC_N; i++) begin : g_sc1
    assign sc1[i] = b1_pend[B1_SC[i]];
  end
  for (genvar j = 0; j < B2_SC_N; j++) begin : g_sc2
    assign sc2[j] = b2_pend[B2_SC[j]];
  end

  always_comb begin
    status_word = '0;
    status_word[LOCAL_N-1:0] = loc_pend;
    status_word[SUM1_BIT] = |b1_pend;
    status_word[SUM2_BIT] = |b2_pend;
    status_word[SC2_BASE-1:SC1_BASE] = sc1;
    status_word[USED_W-1:SC2_BASE] = sc2;
  end

  assign any_pend = (|loc_pend) | (|b1_pend) | (|b2_pend);

  // R7
  sc1_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|status_word[SC2_BASE-1:SC1_BASE]) |-> status_word[SUM1_BIT]);
  // R7
  sc2_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|status_word[USED_W-1:SC2_BASE]) |-> status_word[SUM2_BIT]);
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import banked_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [LOCAL_N-1:0] local_lvl,
  input  logic [BANK_W-1:0] bank1_lvl,
  input  logic [BANK_W-1:0] bank2_lvl,
  output logic              irq_out
);
  logic [LOCAL_N-1:0] en_loc;
  logic [BANK_W-1:0]  en_b1, en_b2, pend_b1, pend_b2;
  logic [DATA_W-1:0]  status_word;
  logic               any_pend;

  irq_mask_group #(.W(LOCAL_N)) u_mask_loc (
    .clk(clk), .rst_n(rst_n),
    .set_we(reg_wr && reg_addr == OFS_LOC_SET),
    .clr_we(reg_wr && reg_addr == OFS_LOC_CLR),
    .wdata(reg_wdata[LOCAL_N-1:0]), .en(en_loc));

  irq_mask_group #(.W(BANK_W)) u_mask_b1 (
    .clk(clk), .rst_n(rst_n),
    .set_we(reg_wr && reg_addr == OFS_B1_SET),
    .clr_we(reg_wr && reg_addr == OFS_B1_CLR),
    .wdata(reg_wdata[BANK_W-1:0]), .en(en_b1));

  irq_mask_group #(.W(BANK_W)) u_mask_b2 (
    .clk(clk), .rst_n(rst_n),
    .set_we(reg_wr && reg_addr == OFS_B2_SET),
    .clr_we(reg_wr && reg_addr == OFS_B2_CLR),
    .wdata(reg_wdata[BANK_W-1:0]), .en(en_b2));

  irq_status_view u_view (
    .clk(clk), .rst_n(rst_n),
    .loc_lvl(local_lvl), .loc_en(en_loc),
    .b1_lvl(bank1_lvl), .b1_en(en_b1),
    .b2_lvl(bank2_lvl), .b2_en(en_b2),
    .b1_pend(pend_b1), .b2_pend(pend_b2),
    .status_word(status_word), .any_pend(any_pend));

  always_comb begin
    unique case (reg_addr)
      OFS_STATUS:               reg_rdata = status_word;
      OFS_B1_PEND:              reg_rdata = DATA_W'(pend_b1);
      OFS_B2_PEND:              reg_rdata = DATA_W'(pend_b2);
      OFS_B1_SET, OFS_B1_CLR:   reg_rdata = DATA_W'(en_b1);
      OFS_B2_SET, OFS_B2_CLR:   reg_rdata = DATA_W'(en_b2);
      OFS_LOC_SET, OFS_LOC_CLR: reg_rdata = DATA_W'(en_loc);
      default:                  reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= any_pend;
  end

  // R11
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_out == $past(any_pend)));
  // R9
  top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == OFS_STATUS) |-> (reg_rdata[DATA_W-1:USED_W] == '0));
  // R10
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == OFS_RSVD) |-> (reg_rdata == '0));
endmodule

// File: tb/banked_irq_ctrl_tb.sv
module banked_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  local_lvl = '0;
  logic [31:0] bank1_lvl = '0;
  logic [31:0] bank2_lvl = '0;
  logic        irq_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .local_lvl(local_lvl),
    .bank1_lvl(bank1_lvl), .bank2_lvl(bank2_lvl), .irq_out(irq_out));

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic do_write(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic do_read(logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] exp_status(logic [7:0] lp, logic [31:0] p1, logic [31:0] p2);
    logic [31:0] r = '0;
    r[7:0] = lp;
    r[8] = |p1; r[9] = |p2;
    r[10] = p1[7]; r[11] = p1[9]; r[12] = p1[10]; r[13] = p1[18]; r[14] = p1[19];
    r[15] = p2[21]; r[16] = p2[22]; r[17] = p2[23]; r[18] = p2[24];
    r[19] = p2[25]; r[20] = p2[30];
    return r;
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    @(negedge clk);
    local_lvl = '1; bank1_lvl = '1; bank2_lvl = '1;
    for (int a = 0; a <= 'h24; a += 4) begin
      do_read(6'(a), d);
      check("R1 reset read", d, 32'h0);
    end
    check("R1 reset irq", {31'b0, irq_out}, 32'h0);
    local_lvl = '0; bank1_lvl = '0; bank2_lvl = '0;
  endtask

  task automatic t_local();
    logic [31:0] d;
    do_write(6'h18, 32'hFFFF_FF0F);
    do_read(6'h18, d); check("R2 local set", d, 32'h0000_000F);
    do_write(6'h18, 32'h0000_0030);
    do_read(6'h18, d); check("R2 local set keeps others", d, 32'h0000_003F);
    do_read(6'h24, d); check("R4 local clr readback", d, 32'h0000_003F);
    do_write(6'h24, 32'h0000_0005);
    do_read(6'h18, d); check("R3 local clear", d, 32'h0000_003A);
    local_lvl = 8'hFF;
    do_read(6'h00, d); check("R6 local pending", d, 32'h0000_003A);
    local_lvl = 8'h0;
    do_write(6'h24, 32'hFF);
  endtask

  task automatic t_bank_pending();
    logic [31:0] d;
    do_write(6'h10, 32'hF0F0_0001);
    do_write(6'h14, 32'h8000_0100);
    do_read(6'h1C, d); check("R4 bank1 clr readback", d, 32'hF0F0_0001);
    do_read(6'h20, d); check("R4 bank2 clr readback", d, 32'h8000_0100);
    bank1_lvl = 32'h3030_0003; bank2_lvl = 32'hFFFF_FFFF;
    do_read(6'h04, d); check("R5 bank1 pending", d, 32'h3030_0001);
    do_read(6'h08, d); check("R5 bank2 pending", d, 32'h8000_0100);
    do_read(6'h00, d); check("R7 summaries", d, 32'h0000_0300);
    do_write(6'h1C, 32'hF0F0_0000);
    do_read(6'h10, d); check("R3 bank1 clear", d, 32'h0000_0001);
    bank1_lvl = 32'h0000_0002;
    do_read(6'h00, d); check("R7 no bank1 summary", d, 32'h0000_0200);
    do_write(6'h1C, '1); do_write(6'h20, '1);
    bank1_lvl = '0; bank2_lvl = '0;
  endtask

  task automatic t_shortcuts();
    logic [31:0] d;
    int s1 [5] = '{7, 9, 10, 18, 19};
    int s2 [6] = '{21, 22, 23, 24, 25, 30};
    do_write(6'h10, '1); do_write(6'h14, '1);
    foreach (s1[i]) begin
      bank1_lvl = 32'h1 << s1[i];
      do_read(6'h00, d);
      check("R8 bank1 shortcut", d, exp_status(8'h0, bank1_lvl, 32'h0));
    end
    bank1_lvl = '0;
    foreach (s2[i]) begin
      bank2_lvl = 32'h1 << s2[i];
      do_read(6'h00, d);
      check("R8 bank2 shortcut", d, exp_status(8'h0, 32'h0, bank2_lvl));
    end
    do_write(6'h18, '1);
    local_lvl = '1; bank1_lvl = '1; bank2_lvl = '1;
    do_read(6'h00, d);
    check("R9 upper bits zero", {21'b0, d[31:21]}, 32'h0);
    check("R8 full word", d, exp_status(8'hFF, '1, '1));
    local_lvl = '0; bank1_lvl = '0; bank2_lvl = '0;
    do_write(6'h24, '1); do_write(6'h1C, '1); do_write(6'h20, '1);
  endtask

  task automatic t_readonly();
    logic [31:0] d;
    do_write(6'h10, 32'h0000_00F0);
    do_write(6'h00, '1); do_write(6'h04, '1);
    do_write(6'h08, '1); do_write(6'h0C, '1);
    do_read(6'h0C, d); check("R10 reserved reads zero", d, 32'h0);
    do_read(6'h10, d); check("R10 bank1 mask untouched", d, 32'h0000_00F0);
    do_read(6'h14, d); check("R10 bank2 mask untouched", d, 32'h0);
    do_read(6'h18, d); check("R10 local mask untouched", d, 32'h0);
    do_read(6'h28, d); check("R12 unmapped reads zero", d, 32'h0);
    do_read(6'h3C, d); check("R12 unmapped top reads zero", d, 32'h0);
    do_write(6'h1C, '1);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    bank2_lvl = 32'h0000_0010;
    @(negedge clk);
    check("R11 disabled source no irq", {31'b0, irq_out}, 32'h0);
    do_write(6'h14, 32'h0000_0010);
    check("R11 irq not yet", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    check("R11 irq rises", {31'b0, irq_out}, 32'h1);
    repeat (3) @(negedge clk);
    check("R11 irq holds", {31'b0, irq_out}, 32'h1);
    local_lvl = 8'h01;
    do_write(6'h18, 32'h01);
    bank2_lvl = '0;
    #1;
    do_read(6'h00, d); check("R12 same-cycle read", d, 32'h0000_0001);
    @(negedge clk);
    check("R11 irq holds on other source", {31'b0, irq_out}, 32'h1);
    local_lvl = '0;
    #1;
    check("R11 irq still high same cycle", {31'b0, irq_out}, 32'h1);
    @(negedge clk);
    check("R11 irq falls", {31'b0, irq_out}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_local();
    t_bank_pending();
    t_shortcuts();
    t_readonly();
    t_irq();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule